// File: doc/BRIEF.md
# Packed Command List Parser

This block walks a command list held in memory and hands each command it finds to the units downstream. The host writes the byte address where the list begins. The parser then reads 32-bit words by itself. It lines up the byte stream so that each command starts at byte zero of a small shift buffer. It works out the command's size from the first byte alone, and delivers the decoded command on a valid/ready output.

Commands are packed back to back with no padding and no alignment, so a command may span two memory words. A halt command ends the list. An opcode the parser does not know also ends the list, sets an error flag and records the byte address of the bad opcode. No-op bytes are consumed silently. Clear and flush commands are sent downstream. The clear command's two flag bits are broken out as separate outputs.

Top module: `cmd_stream_parser`

## Requirements
- R1: After reset, busy, done, error, cmd_valid and mem_req are all low.
- R2: A start write begins a run. The first read is issued to the start address rounded down to a multiple of 4. Each later read goes to the previous read address plus 4. No new read is issued until the previous one has returned on mem_rvalid.
- R3: Each read word is little-endian: the byte at the lowest address sits in bits 7:0. Bytes below the start address in the first word are discarded. Commands are taken in address order with no gaps, including commands that span a word boundary.
- R4: Opcode 25 (clear) is 2 bytes long. cmd_pay carries its second byte, cmd_clr_all equals bit 0 of that byte, and cmd_clr_zs equals bit 1 of that byte.
- R5: Opcode 2 (flush) is 1 byte long. It is emitted with cmd_pay, cmd_clr_all and cmd_clr_zs all zero.
- R6: Opcode 0 (no-op) is 1 byte long. It is consumed and never appears on the command output.
- R7: Opcode 1 (halt) is 1 byte long. It is not emitted. It drops busy and raises done, and no command located after it is emitted.
- R8: Any other opcode is not emitted. It drops busy, raises error with done low, and sets err_addr to the byte address of that opcode. Commands located before it are still emitted.
- R9: While cmd_valid is high and cmd_ready is low, cmd_valid stays high and cmd_op and cmd_pay stay unchanged. No command is lost or repeated.
- R10: A start write is taken only when busy is low and no read is outstanding. A start write made while busy has no effect on the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_wr | input | 1 | Host write strobe for the start address |
| start_addr | input | AW | Byte address of the first command |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run ended on a halt |
| error | output | 1 | The last run ended on an unknown opcode |
| err_addr | output | AW | Byte address of the unknown opcode |
| mem_req | output | 1 | Read request, one cycle per word |
| mem_addr | output | AW | Word-aligned byte address of the read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data, little-endian |
| cmd_valid | output | 1 | Decoded command available |
| cmd_ready | input | 1 | Downstream accepts the command |
| cmd_op | output | 8 | Opcode of the command |
| cmd_pay | output | 8 | Payload byte, zero for flush |
| cmd_clr_all | output | 1 | Clear all render targets flag |
| cmd_clr_zs | output | 1 | Clear depth/stencil flag |

## Verification
A command appears on the output register one clock after the buffer holds all of its bytes. It is retired on the edge where cmd_valid and cmd_ready are both high. The bench therefore compares each command against its own expected list only on handshake edges, and checks the hold rule on the edge after every stalled edge. The bench drives inputs on the falling edge and samples on the rising edge. Done, error and err_addr take a number of cycles that varies with read latency and ready pattern, so the bench polls for the end of the run with a bound. It then checks the flags, the error address and the command count, and it checks again several cycles later to confirm that nothing more was emitted. Read addresses are checked on each request edge against a running expected address.

// File: rtl/cmd_stream_parser.sv
module cmd_stream_parser #(
  parameter int AW = 16,
  parameter int BUF_BYTES = 8,
  parameter logic [7:0] OP_NOP = 8'd0,
  parameter logic [7:0] OP_HALT = 8'd1,
  parameter logic [7:0] OP_FLUSH = 8'd2,
  parameter logic [7:0] OP_CLEAR = 8'd25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_wr,
  input  logic [AW-1:0] start_addr,
  output logic          busy,
  output logic          done,
  output logic          error,
  output logic [AW-1:0] err_addr,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [7:0]    cmd_op,
  output logic [7:0]    cmd_pay,
  output logic          cmd_clr_all,
  output logic          cmd_clr_zs
);
  localparam int CW = $clog2(BUF_BYTES + 1);
  localparam int BW = 8 * BUF_BYTES;

  logic          pend, first;
  logic [CW-1:0] cnt;
  logic [BW-1:0] buff;
  logic [AW-1:0] head, faddr;

  wire [7:0]    op       = buff[7:0];
  wire          known    = op inside {OP_NOP, OP_HALT, OP_FLUSH, OP_CLEAR};
  wire [CW-1:0] need     = CW'((op == OP_CLEAR) ? 2 : 1);
  wire          out_free = !cmd_valid || cmd_ready;
  wire          act      = busy && (cnt != '0) && (!known || cnt >= need) && out_free;
  wire          emit     = act && (op == OP_FLUSH || op == OP_CLEAR);
  wire [CW-1:0] take     = (act && known) ? need : '0;
  wire [1:0]    skip     = first ? head[1:0] : 2'd0;
  wire          take_in  = mem_rvalid && pend && busy;
  wire [CW-1:0] in_n     = CW'(4 - skip);
  wire [BW-1:0] kept     = buff >> (8 * take);
  wire [BW-1:0] fresh    = BW'(mem_rdata >> (8 * skip)) << (8 * (cnt - take));

  assign mem_req     = busy && !pend && (cnt <= CW'(BUF_BYTES - 4));
  assign mem_addr    = faddr;
  assign cmd_clr_all = cmd_pay[0];
  assign cmd_clr_zs  = cmd_pay[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; error <= 1'b0; err_addr <= '0;
      pend <= 1'b0; first <= 1'b0; cnt <= '0; buff <= '0;
      head <= '0; faddr <= '0;
      cmd_valid <= 1'b0; cmd_op <= '0; cmd_pay <= '0;
    end else begin
      if (mem_req) begin
        pend  <= 1'b1;
        faddr <= faddr + AW'(4);
      end
      if (mem_rvalid && pend) begin
        pend  <= 1'b0;
        first <= 1'b0;
      end
      if (start_wr && !busy && !pend) begin
        busy  <= 1'b1;
        done  <= 1'b0;
        error <= 1'b0;
        cnt   <= '0;
        buff  <= '0;
        head  <= start_addr;
        faddr <= {start_addr[AW-1:2], 2'b00};
        first <= 1'b1;
      end else if (busy) begin
        buff <= take_in ? (kept | fresh) : kept;
        cnt  <= cnt - take + (take_in ? in_n : '0);
        head <= head + AW'(take);
        if (act && !known) begin
          error    <= 1'b1;
          busy     <= 1'b0;
          err_addr <= head;
        end else if (act && op == OP_HALT) begin
          done <= 1'b1;
          busy <= 1'b0;
        end
      end
      if (emit) begin
        cmd_valid <= 1'b1;
        cmd_op    <= op;
        cmd_pay   <= (op == OP_CLEAR) ? buff[15:8] : 8'd0;
      end else if (cmd_ready) begin
        cmd_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cmd_stream_parser_chk.sv
module cmd_stream_parser_chk #(
  parameter int CW = 4,
  parameter int BUF_BYTES = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_wr,
  input logic          busy,
  input logic          done,
  input logic          error,
  input logic          mem_req,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [7:0]    cmd_op,
  input logic [7:0]    cmd_pay,
  input logic [CW-1:0] cnt
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(BUF_BYTES)); // R3
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n) mem_req |=> !mem_req); // R2
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_pay)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !mem_req); // R7
  AST_END_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(done && error)); // R8
  AST_EMIT_OPS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_op == 8'd25 || cmd_op == 8'd2)); // R6
  AST_FLUSH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 8'd2 |-> cmd_pay == 8'd0); // R5
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start_wr |=> busy || done || error); // R10
endmodule

bind cmd_stream_parser cmd_stream_parser_chk #(.CW(CW), .BUF_BYTES(BUF_BYTES)) u_chk (.*);

// File: tb/cmd_stream_parser_tb.sv
module cmd_stream_parser_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic clk = 0, rst_n = 0, start_wr = 0, mem_rvalid = 0, cmd_ready = 0;
  logic [AW-1:0] start_addr = '0;
  logic [31:0] mem_rdata = '0;
  logic busy, done, error, mem_req, cmd_valid, cmd_clr_all, cmd_clr_zs;
  logic [AW-1:0] err_addr, mem_addr;
  logic [7:0] cmd_op, cmd_pay;

  cmd_stream_parser #(.AW(AW)) u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0] mem [0:255];
  int checks = 0, failures = 0, mchecks = 0, mfails = 0;
  int lat = 1, rmode = 0, cyc = 0;
  int lcnt = 0;
  logic mpend = 0;
  logic [AW-1:0] raddr = '0, exp_faddr = '0;
  logic [7:0] exp_op [0:15];
  logic [7:0] exp_pay [0:15];
  int exp_n = 0, got = 0, wp = 0;
  logic hold_chk = 0;
  logic [7:0] prev_op = 0, prev_pay = 0;

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mpend) begin
      if (lcnt <= 1) begin
        mem_rvalid <= 1'b1;
        mem_rdata <= {mem[8'(raddr+3)], mem[8'(raddr+2)], mem[8'(raddr+1)], mem[8'(raddr)]};
        mpend = 1'b0;
      end else lcnt = lcnt - 1;
    end
    if (rst_n && mem_req) begin
      mchecks++;
      if (mem_addr !== exp_faddr) begin
        mfails++;
        $display("FAIL R2 read address act=%0h exp=%0h", mem_addr, exp_faddr);
      end
      exp_faddr = exp_faddr + 4;
      raddr = mem_addr; lcnt = lat; mpend = 1'b1;
    end
  end

  always @(negedge clk) begin
    cyc++;
    cmd_ready = (rmode == 0) ? 1'b1 : (rmode == 1) ? cyc[0] : (cyc % 3 == 0);
  end

  always @(posedge clk) begin
    if (rst_n) begin
      if (hold_chk) begin
        mchecks++;
        if (!cmd_valid || cmd_op !== prev_op || cmd_pay !== prev_pay) begin
          mfails++;
          $display("FAIL R9 hold act=%0b/%0h/%0h exp=1/%0h/%0h", cmd_valid, cmd_op, cmd_pay, prev_op, prev_pay);
        end
      end
      hold_chk = cmd_valid && !cmd_ready;
      prev_op = cmd_op; prev_pay = cmd_pay;
      if (cmd_valid && cmd_ready) begin
        mchecks++;
        if (got >= exp_n) begin
          mfails++;
          $display("FAIL R3 extra command act=%0h exp=none", cmd_op);
        end else if (cmd_op !== exp_op[got] || cmd_pay !== exp_pay[got] ||
                     cmd_clr_all !== exp_pay[got][0] || cmd_clr_zs !== exp_pay[got][1]) begin
          mfails++;
          $display("FAIL R4 R5 command %0d act=%0h/%0h/%0b%0b exp=%0h/%0h/%0b%0b", got, cmd_op, cmd_pay,
                   cmd_clr_zs, cmd_clr_all, exp_op[got], exp_pay[got], exp_pay[got][1], exp_pay[got][0]);
        end
        got++;
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_list(input int base);
    for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
    wp = base; exp_n = 0; got = 0;
  endtask

  task automatic put(input logic [7:0] b);
    mem[wp] = b; wp++;
  endtask

  task automatic nop();   put(8'd0); endtask
  task automatic halt();  put(8'd1); endtask
  task automatic flush(); put(8'd2); exp_op[exp_n] = 8'd2; exp_pay[exp_n] = 8'd0; exp_n++; endtask
  task automatic clr(input logic [7:0] p);
    put(8'd25); put(p); exp_op[exp_n] = 8'd25; exp_pay[exp_n] = p; exp_n++;
  endtask

  task automatic go(input int addr);
    @(negedge clk);
    start_wr = 1; start_addr = AW'(addr);
    exp_faddr = AW'(addr) & ~AW'(3);
    @(negedge clk);
    start_wr = 0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (done || error) break;
    end
    repeat (12) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks + mchecks, failures + mfails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !error && !cmd_valid && !mem_req, "R1 reset state",
        {busy, done, error, cmd_valid, mem_req}, 0);

    for (int off = 0; off < 4; off++)
      for (int l = 1; l <= 3; l++)
        for (int rm = 0; rm < 3; rm++) begin
          logic [7:0] p;
          lat = l; rmode = rm;
          p = 8'(off * 37 + l * 11 + rm * 5);
          clear_list(32 + off);
          nop(); clr(p); flush(); nop(); nop(); clr(~p); flush(); halt();
          go(32 + off);
          wait_end();
          chk(done === 1'b1, "R7 done after halt", done, 1);
          chk(error === 1'b0 && busy === 1'b0, "R7 idle without error", {error, busy}, 0);
          chk(got == exp_n, "R3 R6 command count", got, exp_n);
        end

    for (int off = 0; off < 4; off++) begin
      lat = off % 3 + 1; rmode = off % 3;
      clear_list(100 + off);
      clr(8'h03); flush(); put(8'h07); flush();
      exp_n = 2;
      go(100 + off);
      wait_end();
      chk(error === 1'b1 && done === 1'b0, "R8 error flag", {error, done}, 2);
      chk(err_addr === AW'(103 + off), "R8 error address", err_addr, 103 + off);
      chk(busy === 1'b0, "R8 stopped", busy, 0);
      chk(got == 2, "R8 commands before error", got, 2);
    end

    lat = 3; rmode = 1;
    clear_list(160);
    for (int i = 0; i < 6; i++) nop();
    clr(8'hA5); halt();
    wp = 200; put(8'd2); put(8'd1);
    go(160);
    @(negedge clk);
    chk(busy === 1'b1, "R10 busy before second start", busy, 1);
    @(negedge clk);
    start_wr = 1; start_addr = AW'(200);
    @(negedge clk);
    start_wr = 0;
    wait_end();
    chk(done === 1'b1 && error === 1'b0, "R10 first run completes", {done, error}, 2);
    chk(got == 1, "R10 second start ignored", got, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks + mchecks, failures + mfails);
    $finish;
  end
endmodule